// File: doc/BRIEF.md
# Dual-Byte Timer with Variable-Length PWM

This block is a timer and pulse-width generator built from two byte-wide counters, a low byte and a high byte. A two-bit mode field decides how the pair is used. The pair can run as two independent byte timers, or as a byte timer beside a byte PWM. It can also be chained into one 16-bit timer, or into a PWM whose period is a power of two from 9 to 16 bits long. Timer wrap events are reported as single-cycle pulses per byte, merged onto one interrupt line. The PWM waveform drives one output pin.

Counting advances on the cycle-tick strobe `cyc_tick`. A fast-rate bit lets the two chained modes advance on every clock instead. The bench drives the tick on alternate clocks, so this gives twice the resolution. Software programs a control byte, a 16-bit period and a 16-bit duty through a simple write port. Period and duty are staged and move into the active copies only at the boundary of the period they belong to. While stopped, staged values pass straight through.

Top module: `tpwm_unit`

## Requirements
- R1: After reset the unit is stopped in mode 0, and `pwm_out`, `ovf_lo`, `ovf_hi` and `irq` are all low.
- R2: Control byte at address 0 is {bit7 unused, bits 6:4 width select, bit 3 run, bit 2 fast, bits 1:0 mode}. In mode 0 the low counter wraps after period-low+1 events, where period-low is at address 1. The high counter wraps after period-high+1 events, where period-high is at address 2. Each counter pulses its own overflow output for one cycle after the wrapping event.
- R3: In mode 1 the low byte is a timer as in R2. The high byte is a PWM with a fixed 256-event period: `pwm_out` is high while the high count is below duty-high (address 4), and `ovf_hi` pulses at each period end.
- R4: In mode 2 the counters form one 16-bit timer that wraps after {period-high, period-low}+1 events and pulses `ovf_hi`. `ovf_lo` stays low.
- R5: In mode 3 the 16-bit count has period 2^(9+width select) events. `pwm_out` is high while the count is below {duty-high, duty-low} (duty-low at address 3), and `ovf_hi` pulses at each period end.
- R6: A duty value of zero holds `pwm_out` low for the whole period in modes 1 and 3.
- R7: An event is a clock with `cyc_tick` high. In modes 2 and 3 with the fast bit set, every clock is an event whatever the tick. In modes 0 and 1 the fast bit has no effect.
- R8: Period and duty writes made while running take effect only after the current period of the affected counter ends.
- R9: `irq` is high exactly when `ovf_lo` or `ovf_hi` is high.
- R10: Clearing the run bit forces all outputs low and returns both counters to zero. Setting it again restarts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | Cycle-time strobe that paces counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1/2 period low/high, 3/4 duty low/high) |
| wr_data | input | 8 | Register write data |
| pwm_out | output | 1 | PWM waveform |
| ovf_lo | output | 1 | Low-byte wrap pulse |
| ovf_hi | output | 1 | High-byte or 16-bit wrap pulse |
| irq | output | 1 | Shared interrupt pulse |

## Verification
Two functions can fall in the same clock: a staged period or duty write, and the period boundary that moves staged values into the active copies. Running timers can also have both byte wraps land on one event. The bench provokes these by writing duty and period mid-run in mode 1, and by choosing low and high periods whose wraps coincide. It judges every clock against an arithmetic model that applies the pre-write staged value at a boundary and the new value only from the next one.

// File: rtl/tpwm_pkg.sv
// Shared types and register addresses for the dual-byte timer/PWM unit.
package tpwm_pkg;
    typedef enum logic [1:0] {
        TM_DUAL      = 2'd0,
        TM_TIMER_PWM = 2'd1,
        TM_WIDE      = 2'd2,
        TM_VARPWM    = 2'd3
    } tmode_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_PER_LO = 3'd1;
    localparam logic [2:0] A_PER_HI = 3'd2;
    localparam logic [2:0] A_DUT_LO = 3'd3;
    localparam logic [2:0] A_DUT_HI = 3'd4;
endpackage

// File: rtl/tpwm_regs.sv
// Register file: control byte plus staged period and duty.
// Assumes BW >= 4 + WSEL_W so the control fields fit in one data word.
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int BW     = 8,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [BW-1:0]     wr_data,
    output tmode_e            mode,
    output logic              fast,
    output logic              run,
    output logic [WSEL_W-1:0] wsel,
    output logic [2*BW-1:0]   per_stage,
    output logic [2*BW-1:0]   duty_stage
);
    // Control fields update immediately on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= TM_DUAL;
            fast <= 1'b0;
            run  <= 1'b0;
            wsel <= '0;
        end else if (wr_en && wr_addr == A_CTRL) begin
            mode <= tmode_e'(wr_data[1:0]);
            fast <= wr_data[2];
            run  <= wr_data[3];
            wsel <= wr_data[4 +: WSEL_W];
        end
    end

    // Staged period and duty bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_stage  <= '0;
            duty_stage <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PER_LO: per_stage[BW-1:0]     <= wr_data;
                A_PER_HI: per_stage[2*BW-1:BW]  <= wr_data;
                A_DUT_LO: duty_stage[BW-1:0]    <= wr_data;
                A_DUT_HI: duty_stage[2*BW-1:BW] <= wr_data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/tpwm_rate.sv
// Count-event generator: tick pacing, or every clock in the chained modes when fast is set.
module tpwm_rate
    import tpwm_pkg::*;
(
    input  tmode_e mode,
    input  logic   fast,
    input  logic   run,
    input  logic   tick,
    output logic   wide,
    output logic   ev
);
    // Chained modes have mode bit 1 set; only they honour the fast rate.
    always_comb begin
        wide = mode[1];
        ev   = run && ((fast && wide) || tick);
    end
endmodule

// File: rtl/tpwm_bytecnt.sv
// One counter byte: synchronous clear has priority over increment.
module tpwm_bytecnt #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [BW-1:0] cnt
);
    // Clear, count or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tpwm_shadow.sv
// Active copy of a staged 16-bit value, loaded byte lane by byte lane.
// Assumes the caller asserts both loads together in chained modes.
module tpwm_shadow #(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_lo,
    input  logic            load_hi,
    input  logic [2*BW-1:0] stage,
    output logic [2*BW-1:0] act
);
    logic [1:0] load;
    assign load = {load_hi, load_lo};

    for (genvar g = 0; g < 2; g++) begin : g_lane
        // Capture this lane at its own boundary.
        always_ff @(posedge clk) begin
            if (!rst_n)       act[g*BW +: BW] <= '0;
            else if (load[g]) act[g*BW +: BW] <= stage[g*BW +: BW];
        end
    end
endmodule

// File: rtl/tpwm_unit.sv
// Dual-byte timer with 8-bit PWM and variable 9..2*BW-bit PWM.
// Assumes cyc_tick is a single-clock strobe; mode changes are made while stopped.
module tpwm_unit
    import tpwm_pkg::*;
#(
    parameter int BW     = 8,
    parameter int WSEL_W = $clog2(BW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_tick,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [BW-1:0] wr_data,
    output logic          pwm_out,
    output logic          ovf_lo,
    output logic          ovf_hi,
    output logic          irq
);
    localparam int W2 = 2 * BW;

    tmode_e            mode_q;
    logic              fast_q, run_q, wide, ev;
    logic [WSEL_W-1:0] wsel_q;
    logic [W2-1:0]     per_stage, duty_stage, per_act, duty_act;
    logic [BW-1:0]     lo_cnt, hi_cnt, hi_lim;
    logic [W2-1:0]     cnt16, lim16, lim_var;
    logic [W2:0]       pow_var;
    logic              lo_hit, hi_hit, wrap16;
    logic              lo_clr, hi_clr, hi_inc;
    logic              ovf_lo_q, ovf_hi_q;

    tpwm_regs #(.BW(BW), .WSEL_W(WSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode_q), .fast(fast_q), .run(run_q), .wsel(wsel_q),
        .per_stage(per_stage), .duty_stage(duty_stage)
    );

    tpwm_rate u_rate (
        .mode(mode_q), .fast(fast_q), .run(run_q), .tick(cyc_tick),
        .wide(wide), .ev(ev)
    );

    // Wrap detection for byte and chained operation.
    always_comb begin
        cnt16   = {hi_cnt, lo_cnt};
        pow_var = (W2+1)'(1) << (BW + 1 + int'(wsel_q));
        lim_var = pow_var[W2-1:0] - 1'b1;
        lim16   = (mode_q == TM_WIDE) ? per_act : lim_var;
        wrap16  = (cnt16 == lim16);
        lo_hit  = (lo_cnt == per_act[BW-1:0]);
        hi_lim  = (mode_q == TM_TIMER_PWM) ? {BW{1'b1}} : per_act[W2-1:BW];
        hi_hit  = (hi_cnt == hi_lim);
    end

    // Clear and increment controls for both counter bytes.
    always_comb begin
        lo_clr = !run_q || (ev && (wide ? wrap16 : lo_hit));
        hi_clr = !run_q || (ev && (wide ? wrap16 : hi_hit));
        hi_inc = ev && (!wide || (lo_cnt == {BW{1'b1}}));
    end

    tpwm_bytecnt #(.BW(BW)) u_lo (
        .clk(clk), .rst_n(rst_n), .clr(lo_clr), .inc(ev), .cnt(lo_cnt)
    );
    tpwm_bytecnt #(.BW(BW)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(hi_clr), .inc(hi_inc), .cnt(hi_cnt)
    );

    tpwm_shadow #(.BW(BW)) u_per (
        .clk(clk), .rst_n(rst_n), .load_lo(lo_clr), .load_hi(hi_clr),
        .stage(per_stage), .act(per_act)
    );
    tpwm_shadow #(.BW(BW)) u_duty (
        .clk(clk), .rst_n(rst_n), .load_lo(lo_clr), .load_hi(hi_clr),
        .stage(duty_stage), .act(duty_act)
    );

    // Registered single-cycle wrap pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_lo_q <= 1'b0;
            ovf_hi_q <= 1'b0;
        end else begin
            ovf_lo_q <= ev && !wide && lo_hit;
            ovf_hi_q <= ev && (wide ? wrap16 : hi_hit);
        end
    end

    // PWM level from the active count and active duty.
    always_comb begin
        case (mode_q)
            TM_TIMER_PWM: pwm_out = run_q && (hi_cnt < duty_act[W2-1:BW]);
            TM_VARPWM:    pwm_out = run_q && (cnt16 < duty_act);
            default:      pwm_out = 1'b0;
        endcase
    end

    assign ovf_lo = ovf_lo_q;
    assign ovf_hi = ovf_hi_q;
    assign irq    = ovf_lo_q | ovf_hi_q;
endmodule

// File: rtl/tpwm_checker.sv
// Temporal properties of the timer/PWM unit, bound to every instance.
module tpwm_checker #(
    parameter int BW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cyc_tick,
    input logic            run_q,
    input logic            fast_q,
    input logic [1:0]      mode_q,
    input logic [BW-1:0]   lo_cnt,
    input logic [BW-1:0]   hi_cnt,
    input logic [2*BW-1:0] duty_act,
    input logic            pwm_out,
    input logic            ovf_lo,
    input logic            ovf_hi
);
    p_quiet_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q && !$past(run_q) |-> !pwm_out && !ovf_lo && !ovf_hi);

    p_no_lo_in_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && mode_q[1] && $past(run_q && mode_q[1]) |-> !ovf_lo);

    p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        duty_act == '0 |-> !pwm_out);

    p_slow_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_lo || ovf_hi) && !$past(fast_q && mode_q[1]) |-> $past(cyc_tick));

    p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && $past(run_q) && !$past(cyc_tick) && !$past(fast_q && mode_q[1])
        |-> $stable(lo_cnt) && $stable(hi_cnt));

    p_wrap_to_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hi && mode_q[1] && $stable(mode_q) |-> hi_cnt == '0 && lo_cnt == '0);
endmodule

bind tpwm_unit tpwm_checker #(.BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .run_q(run_q), .fast_q(fast_q),
    .mode_q(mode_q), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .duty_act(duty_act),
    .pwm_out(pwm_out), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi)
);

// File: tb/sim_tpwm_unit.sv
// Cycle-by-cycle bench with an arithmetic model of counts, boundaries and staging.
module sim_tpwm_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_out, ovf_lo, ovf_hi, irq;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    tpwm_unit u0 (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .ovf_lo(ovf_lo), .ovf_hi(ovf_hi), .irq(irq)
    );

    // Model state
    bit       m_run, m_fast;
    bit [1:0] m_mode;
    bit [2:0] m_w;
    bit [7:0] s_pl, s_ph, s_dl, s_dh, a_pl, a_ph, a_dl, a_dh, m_lo, m_hi;
    bit       e_lo, e_hi;

    function automatic bit [7:0] ctrl(input int w, input bit run, input bit fast, input int mode);
        return {1'b0, 3'(w), run, fast, 2'(mode)};
    endfunction

    task automatic chk(input string what, input string t, input logic got, input bit exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %0b exp %0b at %0t", t, what, got, exp, $time);
        end
    endtask

    task automatic step(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
        bit ev;
        int lim, v, per;
        bit exp_pwm;
        cyc_tick = t; wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        ev = m_run && ((m_fast && m_mode[1]) || t);
        e_lo = 0; e_hi = 0;
        if (!m_run) begin
            a_pl = s_pl; a_ph = s_ph; a_dl = s_dl; a_dh = s_dh; m_lo = 0; m_hi = 0;
        end else if (ev) begin
            if (m_mode[1]) begin
                lim = (m_mode == 2) ? {a_ph, a_pl} : ((1 << (9 + m_w)) - 1);
                v = {m_hi, m_lo};
                if (v == lim) begin
                    v = 0; e_hi = 1;
                    a_pl = s_pl; a_ph = s_ph; a_dl = s_dl; a_dh = s_dh;
                end else v++;
                m_hi = 8'(v >> 8); m_lo = 8'(v);
            end else begin
                if (m_lo == a_pl) begin m_lo = 0; e_lo = 1; a_pl = s_pl; a_dl = s_dl; end
                else m_lo++;
                per = (m_mode == 1) ? 255 : a_ph;
                if (m_hi == per) begin m_hi = 0; e_hi = 1; a_ph = s_ph; a_dh = s_dh; end
                else m_hi++;
            end
        end
        if (w) case (a)
            3'd0: {m_w, m_run, m_fast, m_mode} = d[6:0];
            3'd1: s_pl = d;
            3'd2: s_ph = d;
            3'd3: s_dl = d;
            3'd4: s_dh = d;
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
        exp_pwm = m_run && ((m_mode == 1) ? (m_hi < a_dh) :
                            (m_mode == 3) ? ({m_hi, m_lo} < {a_dh, a_dl}) : 1'b0);
        chk("pwm_out", tag, pwm_out, exp_pwm);
        chk("ovf_lo", tag, ovf_lo, e_lo);
        chk("ovf_hi", tag, ovf_hi, e_hi);
        chk("irq", "R9", irq, e_lo | e_hi);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    task automatic run_for(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            case (pat)
                0: step(1'b1, 1'b0, 3'd0, 8'd0);
                1: step(1'b0, 1'b0, 3'd0, 8'd0);
                2: step(i % 2 == 1, 1'b0, 3'd0, 8'd0);
                default: step(i % 3 != 2, 1'b0, 3'd0, 8'd0);
            endcase
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("pwm_out", "R1", pwm_out, 1'b0);
        chk("ovf_hi", "R1", ovf_hi, 1'b0);
        rst_n = 1'b1;
        run_for(10, 0);

        // R2: two independent byte timers, irregular tick
        tag = "R2";
        wr(3'd1, 8'd4); wr(3'd2, 8'd6);
        wr(3'd0, ctrl(0, 1, 0, 0));
        run_for(150, 3);
        wr(3'd1, 8'd5); wr(3'd2, 8'd2);   // coinciding wraps later in the run
        run_for(120, 0);
        wr(3'd0, ctrl(0, 0, 0, 0));

        // R3: byte timer plus 8-bit PWM
        tag = "R3";
        wr(3'd1, 8'd2); wr(3'd4, 8'h40);
        wr(3'd0, ctrl(0, 1, 0, 1));
        run_for(600, 0);

        // R8: staged writes while running
        tag = "R8";
        wr(3'd4, 8'hC0);
        run_for(400, 0);
        wr(3'd1, 8'd5);
        run_for(60, 0);

        // R10: stop and restart
        tag = "R10";
        wr(3'd0, ctrl(0, 0, 0, 1));
        run_for(5, 0);
        wr(3'd0, ctrl(0, 1, 0, 1));
        run_for(30, 0);
        wr(3'd0, ctrl(0, 0, 0, 0));

        // R4: 16-bit timer on alternate ticks
        tag = "R4";
        wr(3'd1, 8'h05); wr(3'd2, 8'h01);
        wr(3'd0, ctrl(0, 1, 0, 2));
        run_for(700, 2);
        wr(3'd0, ctrl(0, 0, 0, 2));

        // R7: fast rate in chained mode, no effect in byte mode
        tag = "R7";
        wr(3'd0, ctrl(0, 1, 1, 2));
        run_for(600, 1);
        wr(3'd0, ctrl(0, 0, 0, 0));
        wr(3'd1, 8'd3);
        wr(3'd0, ctrl(0, 1, 1, 0));
        run_for(50, 1);
        wr(3'd0, ctrl(0, 0, 0, 0));

        // R5: variable-width PWM, 9 bits fast then 10 bits on ticks
        tag = "R5";
        wr(3'd3, 8'h23); wr(3'd4, 8'h01);
        wr(3'd0, ctrl(0, 1, 1, 3));
        run_for(1100, 1);
        wr(3'd0, ctrl(1, 0, 0, 3));
        wr(3'd3, 8'h00); wr(3'd4, 8'h03);
        wr(3'd0, ctrl(1, 1, 0, 3));
        run_for(2100, 0);
        wr(3'd0, ctrl(0, 0, 0, 0));

        // R6: zero duty in both PWM modes
        tag = "R6";
        wr(3'd3, 8'h00); wr(3'd4, 8'h00);
        wr(3'd0, ctrl(0, 1, 1, 3));
        run_for(600, 1);
        wr(3'd0, ctrl(0, 0, 0, 1));
        wr(3'd0, ctrl(0, 1, 0, 1));
        run_for(300, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule